// File: doc/BRIEF.md
# Serial Receiver with Status and Interrupts

This block turns an asynchronous serial input into parallel data words of 5 to 8 bits. It samples the line on a 16x oversampling clock enable supplied from outside, confirms each start bit at its middle, and takes every later bit at its midpoint. The block checks an optional parity bit and the first stop bit. It keeps a status byte with three error flags, a receive-full flag, the live modem-line levels and a pending-interrupt flag.

The host sees the received word and the status byte as plain outputs. It reports a read of either register with a one-cycle strobe, and those reads clear the related flags. The block drives an active-low interrupt request and an active-low receive handshake that tells the remote sender to pause. A host-controlled command byte selects parity, interrupt masking, receiver enable and an echo mode, in which the incoming line is looped straight back to the transmit pin.

Top module: `serial_rx_status`

## Requirements
- R1: Bits arrive LSB first. `wordLen` selects the word size: 00 = 8 bits, 01 = 7, 10 = 6, 11 = 5. Bits of `rxData` above the word size read 0, and a parity bit is never stored.
- R2: A low level seen on a tick starts a frame only if the line is still low on the 8th tick. Each following bit is sampled 16 ticks after the previous sample. A shorter low pulse is dropped and loads nothing.
- R3: `cmdWord[5]` = 1 adds a parity bit after the data bits. `cmdWord[7:6]` selects the kind: 00 = odd, 01 = even, 10 = mark, 11 = space. Only odd and even are checked, and a mismatch sets `status[0]`.
- R4: A stop bit sampled low sets the framing error, `status[1]`.
- R5: `status[3]` (receive full) is set when a word is loaded. It is cleared by `rdData`.
- R6: A frame that completes while `status[3]` = 1 sets overrun, `status[2]`. `rxData` keeps the old word and the new word is discarded.
- R7: `status[2:0]` are sticky. They clear only when a frame without parity or framing error is loaded after an `rdData`. None of them raises an interrupt.
- R8: `status[7]` is set by a load when `cmdWord[1]` = 0, or by any change of `dcdN` or `dsrN`. Either event requires `cmdWord[0]` = 1. `rdStatus` clears the bit, but an event in the same cycle keeps it set. `irqN` is low exactly when `status[7]` = 1 and `cmdWord[0]` = 1.
- R9: The receiver runs only when `cmdWord[0]` = 1 and `dcdN` is low. `status[5]` always shows `dcdN`, `status[6]` always shows `dsrN`, and `status[4]` reads 1. After reset, `status` is 0x50 when `dcdN` = 0 and `dsrN` = 1, `irqN` and `hsN` are 1, and `rxData` is 0.
- R10: `hsN` goes low when the start bit is confirmed if `hsEarly` = 1, or when the frame completes if `hsEarly` = 0. It returns high after `rdData`.
- R11: When `cmdWord[4]` = 1 and `cmdWord[3:2]` = 00, `echoTxd` follows `rxd` combinationally. Otherwise it holds 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick16 | input | 1 | One-cycle enable at 16 times the bit rate |
| rxd | input | 1 | Serial data input, idle high |
| dcdN | input | 1 | Carrier-detect level, active low |
| dsrN | input | 1 | Data-set-ready level, active low |
| cmdWord | input | 8 | Command byte: parity, echo, interrupt mask, enable |
| wordLen | input | 2 | Data word size code |
| hsEarly | input | 1 | Handshake timing: 1 = at start bit, 0 = at frame end |
| rdData | input | 1 | Host read strobe for the receive data register |
| rdStatus | input | 1 | Host read strobe for the status register |
| rxData | output | 8 | Received data register |
| status | output | 8 | Status byte |
| irqN | output | 1 | Interrupt request, active low |
| hsN | output | 1 | Receive handshake, low asks sender to stop |
| echoTxd | output | 1 | Transmit pin value in echo mode |

## Verification
A host status read and a new interrupt event can fall in the same clock cycle. In that case the event must win, so the pending flag stays set. The bench provokes this by toggling `dsrN` on the same clock as the `rdStatus` strobe. It expects `status[7]` still at 1 afterwards, and at 0 after a second, quiet read. A parity or framing error arriving with a load is handled the same way: the bench reads the data register and then sends an erroneous frame. It checks that the old error bits survive together with the new one, and that they are cleared only by the next clean frame.

// File: rtl/rxs_pkg.sv
package rxs_pkg;

  // one-cycle event pulses from the bit engine to the status control
  typedef struct packed {
    logic startOk;
    logic done;
    logic parErr;
    logic frmErr;
  } rxEvent_t;

  // strobes from the status control back to the datapath
  typedef struct packed {
    logic loadData;
  } rxCtl_t;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_START,
    PH_DATA,
    PH_PAR,
    PH_STOP
  } rxPhase_t;

endpackage

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tick,
  input  logic              rxd,
  input  logic              rxEnable,
  input  logic [1:0]        wordLen,
  input  logic              parEn,
  input  logic              parCheck,
  input  logic              parEven,
  input  rxCtl_t            ctl,
  output rxEvent_t          ev,
  output logic [DATA_W-1:0] rxData
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(DATA_W);
  localparam int LEN_W = IDX_W + 1;
  localparam int MID   = OVS / 2;

  rxPhase_t          phase;
  logic [CNT_W-1:0]  cnt;
  logic [IDX_W-1:0]  bitIdx;
  logic [DATA_W-1:0] shiftReg;
  logic              parBit;
  logic [LEN_W-1:0]  wordBits;
  logic [IDX_W-1:0]  lastIdx;
  logic              midPoint;

  always_comb begin
    wordBits = LEN_W'(DATA_W) - LEN_W'(wordLen);
    lastIdx  = IDX_W'(wordBits - LEN_W'(1));
    midPoint = (cnt == CNT_W'(OVS - 1));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      bitIdx   <= '0;
      shiftReg <= '0;
      parBit   <= 1'b0;
      ev       <= '0;
      rxData   <= '0;
    end else begin
      ev <= '0;
      if (!rxEnable) begin
        phase <= PH_IDLE;
        cnt   <= '0;
      end else if (tick) begin
        case (phase)
          PH_IDLE: begin
            if (!rxd) begin
              phase <= PH_START;
              cnt   <= CNT_W'(1);
            end
          end
          PH_START: begin
            if (cnt == CNT_W'(MID - 1)) begin
              if (!rxd) begin
                phase      <= PH_DATA;
                cnt        <= '0;
                bitIdx     <= '0;
                shiftReg   <= '0;
                parBit     <= 1'b0;
                ev.startOk <= 1'b1;
              end else begin
                phase <= PH_IDLE;
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_DATA: begin
            if (midPoint) begin
              cnt              <= '0;
              shiftReg[bitIdx] <= rxd;
              if (bitIdx == lastIdx) begin
                phase <= parEn ? PH_PAR : PH_STOP;
              end else begin
                bitIdx <= bitIdx + IDX_W'(1);
              end
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_PAR: begin
            if (midPoint) begin
              cnt    <= '0;
              parBit <= rxd;
              phase  <= PH_STOP;
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          PH_STOP: begin
            if (midPoint) begin
              cnt       <= '0;
              phase     <= PH_IDLE;
              ev.done   <= 1'b1;
              ev.frmErr <= !rxd;
              ev.parErr <= parEn && parCheck && (((^shiftReg) ^ parBit) == parEven);
            end else begin
              cnt <= cnt + CNT_W'(1);
            end
          end
          default: phase <= PH_IDLE;
        endcase
      end
      if (ctl.loadData) rxData <= shiftReg;
    end
  end

  // R2: start confirmation and frame completion never coincide
  a_r2_single_event: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({ev.done, ev.startOk}));

  // R9: a disabled receiver produces no frame events
  a_r9_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !rxEnable |=> !(ev.done || ev.startOk));

endmodule

// File: rtl/rxs_control.sv
module rxs_control
  import rxs_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  rxEvent_t ev,
  input  logic     cmdEnable,
  input  logic     irqMask,
  input  logic     hsEarly,
  input  logic     rdData,
  input  logic     rdStatus,
  input  logic     dcdN,
  input  logic     dsrN,
  output rxCtl_t   ctl,
  output logic     rxFull,
  output logic     ovrErr,
  output logic     frmErrFlag,
  output logic     parErrFlag,
  output logic     irqFlag,
  output logic     irqN,
  output logic     hsN
);

  logic dcdPrev, dsrPrev;
  logic readSeen;
  logic hsLow;
  logic irqSet;
  logic hsSet;
  logic cleanFrame;

  always_comb begin
    ctl.loadData = ev.done && !rxFull;
    cleanFrame   = !ev.parErr && !ev.frmErr;
    irqSet       = cmdEnable && ((ctl.loadData && !irqMask) ||
                                 (dcdN != dcdPrev) || (dsrN != dsrPrev));
    hsSet        = hsEarly ? ev.startOk : ev.done;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dcdPrev    <= 1'b1;
      dsrPrev    <= 1'b1;
      readSeen   <= 1'b0;
      rxFull     <= 1'b0;
      ovrErr     <= 1'b0;
      frmErrFlag <= 1'b0;
      parErrFlag <= 1'b0;
      irqFlag    <= 1'b0;
      hsLow      <= 1'b0;
    end else begin
      dcdPrev <= dcdN;
      dsrPrev <= dsrN;

      if (rdData) rxFull <= 1'b0;
      if (ctl.loadData) begin
        rxFull   <= 1'b1;
        readSeen <= 1'b0;
        if (readSeen && cleanFrame) begin
          parErrFlag <= 1'b0;
          frmErrFlag <= 1'b0;
          ovrErr     <= 1'b0;
        end else begin
          parErrFlag <= parErrFlag | ev.parErr;
          frmErrFlag <= frmErrFlag | ev.frmErr;
        end
      end else if (ev.done) begin
        ovrErr <= 1'b1;
      end
      if (rdData) readSeen <= 1'b1;

      if (irqSet) irqFlag <= 1'b1;
      else if (rdStatus) irqFlag <= 1'b0;

      if (hsSet) hsLow <= 1'b1;
      else if (rdData) hsLow <= 1'b0;
    end
  end

  assign irqN = !(irqFlag && cmdEnable);
  assign hsN  = !hsLow;

  a_r5_full_on_load: assert property (@(posedge clk) disable iff (!rstN)
    (ev.done && !rxFull) |=> rxFull);

  a_r6_overrun_when_busy: assert property (@(posedge clk) disable iff (!rstN)
    (ev.done && rxFull) |=> ovrErr);

  a_r7_parity_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (parErrFlag && !ev.done) |=> parErrFlag);

  a_r8_irq_on_load: assert property (@(posedge clk) disable iff (!rstN)
    (ev.done && !rxFull && cmdEnable && !irqMask) |=> irqFlag);

  a_r10_hs_release: assert property (@(posedge clk) disable iff (!rstN)
    (rdData && !ev.done && !ev.startOk) |=> hsN);

endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status
  import rxs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick16,
  input  logic       rxd,
  input  logic       dcdN,
  input  logic       dsrN,
  input  logic [7:0] cmdWord,
  input  logic [1:0] wordLen,
  input  logic       hsEarly,
  input  logic       rdData,
  input  logic       rdStatus,
  output logic [7:0] rxData,
  output logic [7:0] status,
  output logic       irqN,
  output logic       hsN,
  output logic       echoTxd
);

  rxEvent_t ev;
  rxCtl_t   ctl;
  logic     rxFull, ovrErr, frmErrFlag, parErrFlag, irqFlag;
  logic     rxEnable;

  assign rxEnable = cmdWord[0] && !dcdN;

  rxs_datapath #(.DATA_W(8), .OVS(16)) u_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .tick     (tick16),
    .rxd      (rxd),
    .rxEnable (rxEnable),
    .wordLen  (wordLen),
    .parEn    (cmdWord[5]),
    .parCheck (!cmdWord[7]),
    .parEven  (cmdWord[6]),
    .ctl      (ctl),
    .ev       (ev),
    .rxData   (rxData)
  );

  rxs_control u_control (
    .clk        (clk),
    .rstN       (rstN),
    .ev         (ev),
    .cmdEnable  (cmdWord[0]),
    .irqMask    (cmdWord[1]),
    .hsEarly    (hsEarly),
    .rdData     (rdData),
    .rdStatus   (rdStatus),
    .dcdN       (dcdN),
    .dsrN       (dsrN),
    .ctl        (ctl),
    .rxFull     (rxFull),
    .ovrErr     (ovrErr),
    .frmErrFlag (frmErrFlag),
    .parErrFlag (parErrFlag),
    .irqFlag    (irqFlag),
    .irqN       (irqN),
    .hsN        (hsN)
  );

  assign status  = {irqFlag, dsrN, dcdN, 1'b1, rxFull, ovrErr, frmErrFlag, parErrFlag};
  assign echoTxd = (cmdWord[4] && (cmdWord[3:2] == 2'b00)) ? rxd : 1'b1;

endmodule

// File: tb/serial_rx_status_tb.sv
`timescale 1ns/1ps
module serial_rx_status_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick16 = 1'b0;
  logic       rxd = 1'b1;
  logic       dcdN = 1'b0;
  logic       dsrN = 1'b1;
  logic [7:0] cmdWord = 8'h00;
  logic [1:0] wordLen = 2'b00;
  logic       hsEarly = 1'b0;
  logic       rdData = 1'b0;
  logic       rdStatus = 1'b0;
  logic [7:0] rxData, status;
  logic       irqN, hsN, echoTxd;

  int nChk = 0;
  int nFail = 0;
  bit done = 0;

  // behavioural reference state
  logic [7:0] mData = 8'h00;
  bit mFull = 0, mOvr = 0, mFe = 0, mPe = 0, mIrq = 0, mRead = 0, mHsLow = 0;

  always #2 clk = ~clk;

  serial_rx_status u_dut (
    .clk(clk), .rstN(rstN), .tick16(tick16), .rxd(rxd), .dcdN(dcdN), .dsrN(dsrN),
    .cmdWord(cmdWord), .wordLen(wordLen), .hsEarly(hsEarly), .rdData(rdData),
    .rdStatus(rdStatus), .rxData(rxData), .status(status), .irqN(irqN),
    .hsN(hsN), .echoTxd(echoTxd)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // R11: echo path compared every clock, away from the edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done)
      chk("R11 echo", {7'b0, echoTxd},
          {7'b0, (cmdWord[4] && cmdWord[3:2] == 2'b00) ? rxd : 1'b1});
  end

  function automatic bit xorBits(input logic [7:0] d, input int len);
    bit x = 0;
    for (int i = 0; i < len; i++) x ^= d[i];
    return x;
  endfunction

  function automatic bit rxOn();
    return cmdWord[0] && !dcdN;
  endfunction

  task automatic checkState(input string tag);
    @(negedge clk); #1;
    chk({tag, " rxData"}, rxData, mData);
    chk({tag, " status"}, status, {mIrq, dsrN, dcdN, 1'b1, mFull, mOvr, mFe, mPe});
    chk({tag, " irqN"}, {7'b0, irqN}, {7'b0, !(mIrq && cmdWord[0])});
    chk({tag, " hsN"}, {7'b0, hsN}, {7'b0, !mHsLow});
  endtask

  task automatic waitTicks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick16 = 1'b1;
      @(negedge clk) tick16 = 1'b0;
      @(negedge clk);
      @(negedge clk);
    end
  endtask

  task automatic sendBit(input bit v, input int n);
    rxd = v;
    waitTicks(n);
  endtask

  task automatic modelFrame(input logic [7:0] d, input bit pe, input bit fe);
    if (!rxOn()) return;
    mHsLow = 1;
    if (mFull) mOvr = 1;
    else begin
      mData = d;
      mFull = 1;
      if (mRead && !pe && !fe) begin mPe = 0; mFe = 0; mOvr = 0; end
      else begin mPe |= pe; mFe |= fe; end
      mRead = 0;
      if (cmdWord[0] && !cmdWord[1]) mIrq = 1;
    end
  endtask

  task automatic sendFrame(input logic [7:0] d, input int len, input bit withPar,
                           input bit parVal, input bit goodStop, input bit midCheck);
    sendBit(1'b0, 16);
    for (int i = 0; i < len; i++) begin
      sendBit(d[i], 16);
      if (midCheck && i == 1) begin
        #1;
        chk("R10 handshake timing", {7'b0, hsN}, {7'b0, !(hsEarly || mHsLow)});
      end
    end
    if (withPar) sendBit(parVal, 16);
    if (goodStop) sendBit(1'b1, 16);
    else begin sendBit(1'b0, 10); sendBit(1'b1, 6); end
    sendBit(1'b1, 16);
  endtask

  task automatic readData();
    @(negedge clk) rdData = 1'b1;
    @(negedge clk) rdData = 1'b0;
    mFull = 0; mRead = 1; mHsLow = 0;
  endtask

  task automatic readStatus();
    @(negedge clk) rdStatus = 1'b1;
    @(negedge clk) rdStatus = 1'b0;
    mIrq = 0;
  endtask

  task automatic finishRun();
    done = 1;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  initial begin
    #800000;
    nChk++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    logic [7:0] w;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    checkState("R9 reset");

    // R1 R2 R5 R8 R10: clean 8-bit frame, no parity, interrupt enabled
    cmdWord = 8'b0000_0001;
    repeat (3) @(negedge clk);
    sendFrame(8'hA5, 8, 0, 0, 1, 0); modelFrame(8'hA5, 0, 0);
    checkState("R1 R2 R5 R8 R10 load");
    readStatus(); checkState("R8 status read clears");

    // R6: frame arrives while full
    sendFrame(8'h3C, 8, 0, 0, 1, 0); modelFrame(8'h3C, 0, 0);
    checkState("R6 overrun keeps old");
    readData(); checkState("R5 R7 R10 read keeps overrun");
    sendFrame(8'h11, 8, 0, 0, 1, 0); modelFrame(8'h11, 0, 0);
    checkState("R7 clean frame clears");
    readData(); readStatus();

    // R3: odd parity, 7-bit words, wrong parity bit
    cmdWord = 8'b0010_0001; wordLen = 2'b01;
    w = 8'h55;
    sendFrame(w, 7, 1, xorBits(w, 7), 1, 0); modelFrame(w, 1, 0);
    checkState("R3 odd parity error");
    readData();
    // R4 R7: framing error with good parity, parity error must survive
    w = 8'h2A;
    sendFrame(w, 7, 1, !xorBits(w, 7), 0, 0); modelFrame(w, 0, 1);
    checkState("R4 R7 framing error, sticky parity");
    readData();
    w = 8'h7F;
    sendFrame(w, 7, 1, !xorBits(w, 7), 1, 0); modelFrame(w, 0, 0);
    checkState("R7 clean frame clears errors");
    readData(); readStatus();

    // R3: even parity, correct bit
    cmdWord = 8'b0110_0001; wordLen = 2'b00;
    w = 8'h03;
    sendFrame(w, 8, 1, xorBits(w, 8), 1, 0); modelFrame(w, 0, 0);
    checkState("R3 even parity ok");
    readData(); readStatus();

    // R1 R3 R8: mark parity unchecked, 5-bit word, receive interrupt masked
    cmdWord = 8'b1010_0011; wordLen = 2'b11;
    sendFrame(8'hFF, 5, 1, 0, 1, 0); modelFrame(8'h1F, 0, 0);
    checkState("R1 R3 R8 5-bit mark parity masked irq");
    readData();

    // R8: line change in the same cycle as a status read
    cmdWord = 8'b0000_0001; wordLen = 2'b00;
    @(negedge clk) begin rdStatus = 1'b1; dsrN = 1'b0; end
    @(negedge clk) rdStatus = 1'b0;
    mIrq = 1;
    checkState("R8 event wins over read");
    readStatus(); checkState("R8 quiet read clears");

    // R2 R10: short start pulse is ignored, early handshake
    hsEarly = 1'b1;
    sendBit(1'b0, 4); sendBit(1'b1, 20);
    checkState("R2 glitch ignored");
    sendFrame(8'h81, 8, 0, 0, 1, 1); modelFrame(8'h81, 0, 0);
    checkState("R10 early frame");
    readData(); readStatus();
    hsEarly = 1'b0;
    sendFrame(8'h42, 8, 0, 0, 1, 1); modelFrame(8'h42, 0, 0);
    checkState("R10 late frame");
    readData(); readStatus();

    // R9: carrier lost blocks reception, change raises interrupt
    @(negedge clk) dcdN = 1'b1; mIrq = 1;
    sendFrame(8'h99, 8, 0, 0, 1, 0); modelFrame(8'h99, 0, 0);
    checkState("R9 R8 carrier off");
    readStatus();
    @(negedge clk) dcdN = 1'b0; mIrq = 1;
    checkState("R8 carrier edge");
    readStatus();

    // R9 R8: receiver and interrupts disabled
    cmdWord = 8'h00;
    @(negedge clk) dsrN = 1'b1;
    sendFrame(8'h5A, 8, 0, 0, 1, 0); modelFrame(8'h5A, 0, 0);
    checkState("R9 R8 disabled");

    // R11: echo valid, then echo with transmitter bits set
    cmdWord = 8'b0001_0001;
    sendFrame(8'hC3, 8, 0, 0, 1, 0); modelFrame(8'hC3, 0, 0);
    checkState("R11 echo frame");
    readData();
    cmdWord = 8'b0001_0101;
    sendFrame(8'h3A, 8, 0, 0, 1, 0); modelFrame(8'h3A, 0, 0);
    checkState("R11 echo blocked");
    finishRun();
  end

endmodule